// File: doc/BRIEF.md
# Shared Variable-Page Translation Buffer

This block is a fully associative address translation cache that serves both instruction fetch and data access. Each of its entries maps a pair of adjacent virtual pages onto two physical frames. The lower page of the pair is the even half and the upper page is the odd half. Every entry has its own page mask, so one entry may map a pair of 4 KB pages and the next a pair of 16 MB pages. A lookup sends a 32-bit virtual address and an 8-bit address-space identifier. One cycle later the block returns a 36-bit physical address, the dirty and cache-attribute bits of the selected half, and exactly one of three outcomes: hit, fault or miss.

Maintenance software uses a second port that runs one operation per cycle. An indexed write installs an entry. An indexed read returns the stored entry. A probe searches all entries for a virtual page pair and returns the index of the entry that matches. The page-table walk and exception dispatch sit outside the block.

Top module: `tlb_joint`

## Requirements
- R1: An active-low reset clears every entry to all-zero fields and drives every output to zero.
- R2: A lookup presented with `lk_valid` high at a rising edge raises `lk_done` for the cycle after that edge and carries its results in that cycle. `lk_done` is low after any edge where `lk_valid` was low.
- R3: When `lk_done` is high, exactly one of `lk_hit`, `lk_fault` and `lk_miss` is high. When `lk_done` is low, none of them is high. On a miss or a fault, `lk_pa`, `lk_dirty` and `lk_cattr` are zero.
- R4: An entry matches when its 19-bit page-pair tag equals VA[31:13] on every bit that its mask does not exclude, and its ASID equals `lk_asid` or its global bit is set. No matching entry gives a miss.
- R5: Mask bit j (0..11) excludes VA bit 13+j from the compare and passes VA bit 12+j through to the physical address. The legal masks 0x000, 0x003, 0x00F, 0x03F, 0x0FF, 0x3FF and 0xFFF give page sizes of 4K, 16K, 64K, 256K, 1M, 4M and 16M. The physical address is {pfn,12'h000} with every page-offset bit taken from the virtual address.
- R6: The odd half is selected when VA bit 12+2k is 1, where k is the number of mask bit pairs that are set. For example, VA bit 12 selects for 4K pages, bit 14 for 16K pages and bit 24 for 16M pages.
- R7: A match whose selected half has its valid flag at 0 reports a fault and does not report a hit.
- R8: The 5-bit flags of each half are laid out as bit 0 valid, bit 1 dirty and bits 4:2 cache attribute. On a hit, `lk_dirty` and `lk_cattr` come from the selected half.
- R9: When several entries match, the entry with the lowest index supplies the result.
- R10: `mt_op`=1 (write) stores the write fields into entry `mt_index` at the clock edge. A lookup presented in the next cycle sees the new entry. A write whose index is not below ENTRIES changes nothing.
- R11: `mt_op`=2 (read) shows the fields of entry `mt_index` on the `rd_*` outputs in the following cycle. An index that is not below ENTRIES reads as all zeros.
- R12: `mt_op`=3 (probe) matches `mt_vpn2` and `mt_asid` against every entry under the rules of R4. In the following cycle it returns the lowest matching index with `pr_notfound`=0, or `pr_notfound`=1 with `pr_index`=0 when no entry matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Valid translation found |
| lk_fault | output | 1 | Match on an invalid half |
| lk_miss | output | 1 | No entry matched |
| lk_pa | output | 36 | Translated physical address |
| lk_dirty | output | 1 | Dirty flag of the selected half |
| lk_cattr | output | 3 | Cache attribute of the selected half |
| mt_op | input | 2 | 0 none, 1 write, 2 read, 3 probe |
| mt_index | input | 6 | Entry index for write and read |
| mt_vpn2 | input | 19 | Page-pair tag for write and probe |
| mt_mask | input | 12 | Page mask for write |
| mt_asid | input | 8 | ASID for write and probe |
| mt_global | input | 1 | Global bit for write |
| mt_pfn0 | input | 24 | Even-half frame for write |
| mt_flags0 | input | 5 | Even-half flags for write |
| mt_pfn1 | input | 24 | Odd-half frame for write |
| mt_flags1 | input | 5 | Odd-half flags for write |
| rd_vpn2 | output | 19 | Read-back tag |
| rd_mask | output | 12 | Read-back mask |
| rd_asid | output | 8 | Read-back ASID |
| rd_global | output | 1 | Read-back global bit |
| rd_pfn0 | output | 24 | Read-back even frame |
| rd_flags0 | output | 5 | Read-back even flags |
| rd_pfn1 | output | 24 | Read-back odd frame |
| rd_flags1 | output | 5 | Read-back odd flags |
| pr_index | output | 6 | Probe result index |
| pr_notfound | output | 1 | Probe found no entry |

## Verification
Every result of this block is due one edge after its request. Lookup outcomes come after the edge that sampled `lk_valid`. Read and probe data come after the edge that sampled `mt_op`. A written entry can be seen by a lookup presented in the next cycle. The bench drives each request on a falling edge and holds it through exactly one rising edge. It then samples the outputs on the next falling edge, half a cycle after they settle. One extra idle cycle confirms that `lk_done` drops again.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 36;
    localparam int OFF_W  = 12;
    localparam int MASK_W = 12;
    localparam int ASID_W = 8;
    localparam int VPN2_W = VA_W - OFF_W - 1;
    localparam int PFN_W  = PA_W - OFF_W;
    localparam int FLAG_W = 5;

    typedef struct packed {
        logic [2:0] cattr;
        logic       dirty;
        logic       valid;
    } half_t;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [MASK_W-1:0] mask;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [PFN_W-1:0]  pfn0;
        half_t             f0;
        logic [PFN_W-1:0]  pfn1;
        half_t             f1;
    } entry_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_PROBE = 2'd3
    } op_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  entry_t            ent,
    input  logic [VPN2_W-1:0] vpn2,
    input  logic [ASID_W-1:0] asid,
    output logic              hit
);
    logic [VPN2_W-1:0] care;

    always_comb begin
        care = ~{{(VPN2_W-MASK_W){1'b0}}, ent.mask};
        hit  = (((vpn2 ^ ent.vpn2) & care) == '0) && (ent.glob || (ent.asid == asid));
    end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter  int N     = 48,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
(
    input  entry_t           ent,
    input  logic [VA_W-1:0]  va,
    output logic [PA_W-1:0]  pa,
    output half_t            half
);
    logic [PA_W-1:0]   keep_va;
    logic [MASK_W:0]   sel_bits;
    logic              odd;
    logic [PFN_W-1:0]  pfn;

    always_comb begin
        keep_va = {{(PA_W-OFF_W-MASK_W){1'b0}}, ent.mask, {OFF_W{1'b1}}};
        sel_bits[0]      = ~ent.mask[0];
        sel_bits[MASK_W] = ent.mask[MASK_W-1];
        for (int j = 1; j < MASK_W; j++) begin
            sel_bits[j] = ent.mask[j-1] & ~ent.mask[j];
        end
        odd  = |(va[OFF_W+MASK_W:OFF_W] & sel_bits);
        half = odd ? ent.f1 : ent.f0;
        pfn  = odd ? ent.pfn1 : ent.pfn0;
        pa   = ({pfn, {OFF_W{1'b0}}} & ~keep_va) | ({{(PA_W-VA_W){1'b0}}, va} & keep_va);
    end
endmodule

// File: rtl/tlb_joint.sv
module tlb_joint
    import tlb_pkg::*;
#(
    parameter  int ENTRIES = 48,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_done,
    output logic              lk_hit,
    output logic              lk_fault,
    output logic              lk_miss,
    output logic [PA_W-1:0]   lk_pa,
    output logic              lk_dirty,
    output logic [2:0]        lk_cattr,
    input  logic [1:0]        mt_op,
    input  logic [IDX_W-1:0]  mt_index,
    input  logic [VPN2_W-1:0] mt_vpn2,
    input  logic [MASK_W-1:0] mt_mask,
    input  logic [ASID_W-1:0] mt_asid,
    input  logic              mt_global,
    input  logic [PFN_W-1:0]  mt_pfn0,
    input  logic [FLAG_W-1:0] mt_flags0,
    input  logic [PFN_W-1:0]  mt_pfn1,
    input  logic [FLAG_W-1:0] mt_flags1,
    output logic [VPN2_W-1:0] rd_vpn2,
    output logic [MASK_W-1:0] rd_mask,
    output logic [ASID_W-1:0] rd_asid,
    output logic              rd_global,
    output logic [PFN_W-1:0]  rd_pfn0,
    output logic [FLAG_W-1:0] rd_flags0,
    output logic [PFN_W-1:0]  rd_pfn1,
    output logic [FLAG_W-1:0] rd_flags1,
    output logic [IDX_W-1:0]  pr_index,
    output logic              pr_notfound
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(ENTRIES);

    entry_t             tbl [ENTRIES];
    entry_t             wr_ent;
    entry_t             rd_ent;
    logic [ENTRIES-1:0] lk_vec;
    logic [ENTRIES-1:0] pr_vec;
    logic               lk_found;
    logic               pr_found;
    logic [IDX_W-1:0]   lk_idx;
    logic [IDX_W-1:0]   pr_idx;
    logic [PA_W-1:0]    xl_pa;
    half_t              xl_half;
    logic               idx_ok;
    logic               do_write;
    logic               do_read;
    logic               do_probe;
    op_e                op;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            tlb_match u_lk_cmp (.ent(tbl[g]), .vpn2(lk_va[VA_W-1:OFF_W+1]),
                                .asid(lk_asid), .hit(lk_vec[g]));
            tlb_match u_pr_cmp (.ent(tbl[g]), .vpn2(mt_vpn2),
                                .asid(mt_asid), .hit(pr_vec[g]));
        end
    endgenerate

    tlb_pick #(.N(ENTRIES)) u_lk_pick (.vec(lk_vec), .found(lk_found), .idx(lk_idx));
    tlb_pick #(.N(ENTRIES)) u_pr_pick (.vec(pr_vec), .found(pr_found), .idx(pr_idx));
    tlb_xlate u_xlate (.ent(tbl[lk_idx]), .va(lk_va), .pa(xl_pa), .half(xl_half));

    // maintenance operation decode
    always_comb begin
        op       = op_e'(mt_op);
        idx_ok   = {1'b0, mt_index} < LIMIT;
        do_write = 1'b0;
        do_read  = 1'b0;
        do_probe = 1'b0;
        unique case (op)
            OP_NONE:  ;
            OP_WRITE: do_write = idx_ok;
            OP_READ:  do_read  = 1'b1;
            OP_PROBE: do_probe = 1'b1;
        endcase
        wr_ent = '{vpn2: mt_vpn2, mask: mt_mask, asid: mt_asid, glob: mt_global,
                   pfn0: mt_pfn0, f0: half_t'(mt_flags0),
                   pfn1: mt_pfn1, f1: half_t'(mt_flags1)};
        rd_ent = idx_ok ? tbl[mt_index] : '0;
    end

    // entry storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
        end else if (do_write) begin
            tbl[mt_index] <= wr_ent;
        end
    end

    // lookup results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_done  <= 1'b0;
            lk_hit   <= 1'b0;
            lk_fault <= 1'b0;
            lk_miss  <= 1'b0;
            lk_pa    <= '0;
            lk_dirty <= 1'b0;
            lk_cattr <= '0;
        end else begin
            lk_done  <= lk_valid;
            lk_hit   <= lk_valid && lk_found && xl_half.valid;
            lk_fault <= lk_valid && lk_found && !xl_half.valid;
            lk_miss  <= lk_valid && !lk_found;
            if (lk_valid && lk_found && xl_half.valid) begin
                lk_pa    <= xl_pa;
                lk_dirty <= xl_half.dirty;
                lk_cattr <= xl_half.cattr;
            end else begin
                lk_pa    <= '0;
                lk_dirty <= 1'b0;
                lk_cattr <= '0;
            end
        end
    end

    // read and probe results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {rd_vpn2, rd_mask, rd_asid, rd_global} <= '0;
            {rd_pfn0, rd_flags0, rd_pfn1, rd_flags1} <= '0;
            pr_index    <= '0;
            pr_notfound <= 1'b0;
        end else begin
            if (do_read) begin
                rd_vpn2   <= rd_ent.vpn2;
                rd_mask   <= rd_ent.mask;
                rd_asid   <= rd_ent.asid;
                rd_global <= rd_ent.glob;
                rd_pfn0   <= rd_ent.pfn0;
                rd_flags0 <= rd_ent.f0;
                rd_pfn1   <= rd_ent.pfn1;
                rd_flags1 <= rd_ent.f1;
            end
            if (do_probe) begin
                pr_index    <= pr_found ? pr_idx : '0;
                pr_notfound <= !pr_found;
            end
        end
    end
endmodule

// File: rtl/tlb_joint_chk.sv
module tlb_joint_chk
    import tlb_pkg::*;
#(
    parameter  int ENTRIES = 48,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [VA_W-1:0]  lk_va,
    input logic             lk_done,
    input logic             lk_hit,
    input logic             lk_fault,
    input logic             lk_miss,
    input logic [PA_W-1:0]  lk_pa,
    input logic             lk_dirty,
    input logic [2:0]       lk_cattr,
    input logic [1:0]       mt_op,
    input logic [IDX_W-1:0] pr_index,
    input logic             pr_notfound
);
    AST_LK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_done); // R2
    AST_LK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !lk_done); // R2
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |-> $countones({lk_hit, lk_fault, lk_miss}) == 1); // R3
    AST_NO_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_done |-> !(lk_hit || lk_fault || lk_miss)); // R3
    AST_NOHIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_miss || lk_fault) |-> (lk_pa == '0 && !lk_dirty && lk_cattr == '0)); // R3
    AST_PA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!lk_hit || lk_pa[OFF_W-1:0] == $past(lk_va[OFF_W-1:0]))); // R5
    AST_PROBE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_op == 2'd3) |=> (!pr_notfound || pr_index == '0)); // R12
endmodule

bind tlb_joint tlb_joint_chk #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/tlb_joint_tb.sv
module tlb_joint_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_done, lk_hit, lk_fault, lk_miss, lk_dirty;
    logic [35:0] lk_pa;
    logic [2:0]  lk_cattr;
    logic [1:0]  mt_op = '0;
    logic [5:0]  mt_index = '0;
    logic [18:0] mt_vpn2 = '0;
    logic [11:0] mt_mask = '0;
    logic [7:0]  mt_asid = '0;
    logic        mt_global = 1'b0;
    logic [23:0] mt_pfn0 = '0, mt_pfn1 = '0;
    logic [4:0]  mt_flags0 = '0, mt_flags1 = '0;
    logic [18:0] rd_vpn2;
    logic [11:0] rd_mask;
    logic [7:0]  rd_asid;
    logic        rd_global;
    logic [23:0] rd_pfn0, rd_pfn1;
    logic [4:0]  rd_flags0, rd_flags1;
    logic [5:0]  pr_index;
    logic        pr_notfound;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tlb_joint u_dut (.*);

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // result vector: {done, hit, fault, miss, pa, dirty, cattr}
    function automatic logic [43:0] lk_now();
        return {lk_done, lk_hit, lk_fault, lk_miss, lk_pa, lk_dirty, lk_cattr};
    endfunction

    task automatic do_lookup(input string req, input logic [31:0] va, input logic [7:0] asid,
                             input logic [43:0] exp);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va; lk_asid = asid;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(req, {84'd0, lk_now()}, {84'd0, exp});
    endtask

    task automatic do_write(input logic [5:0] idx, input logic [18:0] vpn2, input logic [11:0] mask,
                            input logic [7:0] asid, input logic g,
                            input logic [23:0] p0, input logic [4:0] f0,
                            input logic [23:0] p1, input logic [4:0] f1);
        @(negedge clk);
        mt_op = 2'd1; mt_index = idx; mt_vpn2 = vpn2; mt_mask = mask; mt_asid = asid;
        mt_global = g; mt_pfn0 = p0; mt_flags0 = f0; mt_pfn1 = p1; mt_flags1 = f1;
        @(negedge clk);
        mt_op = 2'd0;
    endtask

    task automatic do_read(input string req, input logic [5:0] idx, input logic [97:0] exp);
        @(negedge clk);
        mt_op = 2'd2; mt_index = idx;
        @(negedge clk);
        mt_op = 2'd0;
        chk(req, {30'd0, rd_vpn2, rd_mask, rd_asid, rd_global, rd_pfn0, rd_flags0, rd_pfn1, rd_flags1},
            {30'd0, exp});
    endtask

    task automatic do_probe(input string req, input logic [18:0] vpn2, input logic [7:0] asid,
                            input logic nf, input logic [5:0] idx);
        @(negedge clk);
        mt_op = 2'd3; mt_vpn2 = vpn2; mt_asid = asid;
        @(negedge clk);
        mt_op = 2'd0;
        chk(req, {121'd0, pr_notfound, pr_index}, {121'd0, nf, idx});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs", {84'd0, lk_now()}, 128'd0);
        chk("R1 probe outputs", {121'd0, pr_notfound, pr_index}, 128'd0);
        do_read("R1 cleared entry", 6'd5, 98'd0);
        do_lookup("R1 empty table miss", 32'h0040_0ABC, 8'h11, {4'b1001, 36'd0, 1'b0, 3'd0});
    endtask

    task automatic t_small_pages();
        // entry 5: 4K pair, even flags c=3 d=1 v=1, odd flags c=2 d=0 v=1
        do_write(6'd5, 19'h00200, 12'h000, 8'h11, 1'b0, 24'h000123, 5'h0F, 24'h000456, 5'h09);
        do_lookup("R10 R6 R8 even half", 32'h0040_0ABC, 8'h11, {4'b1100, 36'h000123ABC, 1'b1, 3'd3});
        do_lookup("R6 R8 odd half", 32'h0040_1ABC, 8'h11, {4'b1100, 36'h000456ABC, 1'b0, 3'd2});
        chk("R2 done drops", {127'd0, lk_done}, 128'd1);
        @(negedge clk);
        chk("R2 idle no done", {124'd0, lk_done, lk_hit, lk_fault, lk_miss}, 128'd0);
        do_lookup("R4 asid mismatch", 32'h0040_0ABC, 8'h12, {4'b1001, 36'd0, 1'b0, 3'd0});
        do_write(6'd5, 19'h00200, 12'h000, 8'h11, 1'b1, 24'h000123, 5'h0F, 24'h000456, 5'h09);
        do_lookup("R4 global ignores asid", 32'h0040_0ABC, 8'h12, {4'b1100, 36'h000123ABC, 1'b1, 3'd3});
    endtask

    task automatic t_masked_pages();
        // entry 7: 16K pair, odd half invalid
        do_write(6'd7, 19'h08000, 12'h003, 8'h20, 1'b0, 24'h000800, 5'h01, 24'h000900, 5'h00);
        do_lookup("R5 16K even", 32'h1000_2345, 8'h20, {4'b1100, 36'h000802345, 1'b0, 3'd0});
        do_lookup("R7 invalid odd half faults", 32'h1000_6345, 8'h20, {4'b1010, 36'd0, 1'b0, 3'd0});
        // entry 9: 16M pair, global
        do_write(6'd9, 19'h40000, 12'hFFF, 8'h00, 1'b1, 24'h001000, 5'h05, 24'h002000, 5'h07);
        do_lookup("R5 16M even", 32'h80AB_CDEF, 8'h55, {4'b1100, 36'h001ABCDEF, 1'b0, 3'd1});
        do_lookup("R6 16M odd via bit24", 32'h81AB_CDEF, 8'h55, {4'b1100, 36'h002ABCDEF, 1'b1, 3'd1});
        do_lookup("R5 unmasked bit25 miss", 32'h82AB_CDEF, 8'h55, {4'b1001, 36'd0, 1'b0, 3'd0});
    endtask

    task automatic t_priority_probe();
        do_write(6'd2, 19'h00200, 12'h000, 8'h00, 1'b1, 24'h000777, 5'h01, 24'h000778, 5'h01);
        do_lookup("R9 lowest index wins", 32'h0040_0ABC, 8'h11, {4'b1100, 36'h000777ABC, 1'b0, 3'd0});
        do_probe("R12 probe lowest", 19'h00200, 8'h33, 1'b0, 6'd2);
        do_probe("R12 probe masked entry", 19'h08003, 8'h20, 1'b0, 6'd7);
        do_probe("R12 probe asid mismatch", 19'h08000, 8'h21, 1'b1, 6'd0);
        do_probe("R12 probe not found", 19'h00300, 8'h11, 1'b1, 6'd0);
    endtask

    task automatic t_read_range();
        do_read("R11 read entry 7", 6'd7,
                {19'h08000, 12'h003, 8'h20, 1'b0, 24'h000800, 5'h01, 24'h000900, 5'h00});
        do_write(6'd50, 19'h05000, 12'h000, 8'h00, 1'b1, 24'h000ABC, 5'h01, 24'h000ABD, 5'h01);
        do_lookup("R10 out-of-range write ignored", 32'h0A00_0000, 8'h00, {4'b1001, 36'd0, 1'b0, 3'd0});
        do_read("R11 out-of-range read zero", 6'd50, 98'd0);
        do_read("R10 entry 9 intact", 6'd9,
                {19'h40000, 12'hFFF, 8'h00, 1'b1, 24'h001000, 5'h05, 24'h002000, 5'h07});
    endtask

    initial begin
        t_reset();
        t_small_pages();
        t_masked_pages();
        t_priority_probe();
        t_read_range();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule